// File: doc/BRIEF.md
# Block Write-Protection Controller

This block keeps one protection flag for every erase block of a flash array and answers, for any requested block, whether a program or erase operation may proceed. The flags are set to "protected" whenever the block is reset. Software changes them through a short command sequence on a write port. Two unlocking writes are followed by any number of block-addressed writes. Three low address lines of each block-addressed write select protect or unprotect.

Two hardware overrides are applied on top of the stored flags. An active-low write-protect pin locks the edge blocks of the array: both outermost blocks in the boot-layout build, and only the last block in the uniform build. A low-programming-voltage input locks every block. The permit output and the status read port are combinational views of the stored flags and the overrides.

Top module: `blk_wprot_ctrl`

## Requirements
- R1: While reset is low, and at the first clock after it is released, every block's stored flag is 1 (protected), so every permit is 0.
- R2: After the sequence is armed, a write with data 60h and cmd_lines = 3'b010 sets the flag of block cmd_blk at that clock edge. Here cmd_lines[2] is A6, [1] is A1 and [0] is A0. The sequence is armed by two consecutive command writes of data 60h; their cmd_lines and cmd_blk are ignored.
- R3: In the armed state, a write with data 60h and cmd_lines = 3'b110 clears the flag of block cmd_blk at that clock edge.
- R4: Once armed, the sequence stays armed, so any number of further 60h writes each update one block without repeating the two unlock writes. In the armed state, writes of any other data except F0h change nothing.
- R5: A write of data F0h returns the sequencer to normal mode. After it, a single 60h write with a legal cmd_lines value changes no flag.
- R6: In the armed state, a 60h write whose cmd_lines is neither 3'b010 nor 3'b110 leaves every flag unchanged and keeps the sequence armed.
- R7: If the write after the first unlock write carries any data other than 60h, the sequencer falls back to normal mode. The two unlock writes must then be repeated.
- R8: While wp_n is 0, block NUM_BLOCKS-1 is treated as protected. In the boot layout (BOOT_LAYOUT=1), block 0 is treated as protected as well. Stored flags are not altered.
- R9: While vpp_low is 1, every block is treated as protected. Stored flags are not altered.
- R10: req_permit is combinational and equals NOT stored flag AND NOT write-protect override AND NOT voltage override, for block req_blk.
- R11: rd_stored returns the stored flag of block rd_blk. rd_protected returns the effective protection of block rd_blk, which is the stored flag OR either override, combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command write strobe, one write per cycle |
| cmd_data | input | 8 | Command data byte |
| cmd_lines | input | 3 | Selector address lines {A6, A1, A0} |
| cmd_blk | input | BLK_AW | Block address of the command write |
| wp_n | input | 1 | Write-protect pin, active low |
| vpp_low | input | 1 | Programming voltage below threshold |
| req_blk | input | BLK_AW | Block targeted by a program or erase request |
| req_permit | output | 1 | Request allowed for req_blk |
| rd_blk | input | BLK_AW | Block selected for status read |
| rd_stored | output | 1 | Stored flag of rd_blk |
| rd_protected | output | 1 | Effective protection of rd_blk |

## Verification
Every block index is swept after reset, after a bulk unprotect and after an alternating even/odd protect pattern. These sweeps separate a misdecoded block address from a wrong flag value. The same sweeps are repeated with wp_n low and with vpp_low high, on both a boot-layout and a uniform instance, which separates an override that leaks into stored state from one applied to the wrong block. All six illegal selector codes are applied to a protected block and to an unprotected one, to catch a missing decode term. Sequences broken by F0h or by stray data check that a lone 60h after leaving the armed state cannot update a flag.

// File: rtl/blk_wprot_pkg.sv
package blk_wprot_pkg;

   localparam int CMD_W = 8;

   localparam logic [CMD_W-1:0] OP_LOCK = 8'h60;
   localparam logic [CMD_W-1:0] OP_EXIT = 8'hF0;

   // selector lines ordered {A6, A1, A0}
   localparam logic [2:0] SEL_PROTECT   = 3'b010;
   localparam logic [2:0] SEL_UNPROTECT = 3'b110;

   typedef enum logic [1:0] {
      SEQ_IDLE  = 2'd0,
      SEQ_UNLK  = 2'd1,
      SEQ_ARMED = 2'd2
   } seq_state_t;

   function automatic logic sel_is_legal(input logic [2:0] sel);
      return (sel == SEL_PROTECT) || (sel == SEL_UNPROTECT);
   endfunction

endpackage

// File: rtl/blk_wprot_seq.sv
module blk_wprot_seq
   import blk_wprot_pkg::*;
#(
   parameter int BLK_AW = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic [CMD_W-1:0]  cmd_data,
   input  logic [2:0]        cmd_lines,
   input  logic [BLK_AW-1:0] cmd_blk,
   output logic              upd_en,
   output logic              upd_val,
   output logic [BLK_AW-1:0] upd_blk
);

   seq_state_t state_q, state_d;

   logic is_lock, is_exit;
   assign is_lock = cmd_valid && (cmd_data == OP_LOCK);
   assign is_exit = cmd_valid && (cmd_data == OP_EXIT);

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         SEQ_IDLE: begin
            if (is_lock) state_d = SEQ_UNLK;
         end
         SEQ_UNLK: begin
            if (is_lock)        state_d = SEQ_ARMED;
            else if (cmd_valid) state_d = SEQ_IDLE;
         end
         SEQ_ARMED: begin
            if (is_exit) state_d = SEQ_IDLE;
         end
         default: state_d = SEQ_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= SEQ_IDLE;
      else        state_q <= state_d;
   end

   assign upd_en  = (state_q == SEQ_ARMED) && is_lock && sel_is_legal(cmd_lines);
   assign upd_val = (cmd_lines == SEL_PROTECT);
   assign upd_blk = cmd_blk;

endmodule

// File: rtl/blk_wprot_bits.sv
module blk_wprot_bits #(
   parameter int NUM_BLOCKS = 256,
   localparam int BLK_AW = $clog2(NUM_BLOCKS)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  upd_en,
   input  logic                  upd_val,
   input  logic [BLK_AW-1:0]     upd_blk,
   output logic [NUM_BLOCKS-1:0] prot_q
);

   for (genvar i = 0; i < NUM_BLOCKS; i++) begin : g_flag
      logic hit;
      assign hit = upd_en && (upd_blk == BLK_AW'(i));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   prot_q[i] <= 1'b1;
         else if (hit) prot_q[i] <= upd_val;
      end
   end

endmodule

// File: rtl/blk_wprot_hwlock.sv
module blk_wprot_hwlock #(
   parameter int NUM_BLOCKS  = 256,
   parameter bit BOOT_LAYOUT = 1'b1,
   localparam int BLK_AW = $clog2(NUM_BLOCKS),
   localparam logic [BLK_AW-1:0] LAST_BLK = BLK_AW'(NUM_BLOCKS - 1)
) (
   input  logic              wp_n,
   input  logic              vpp_low,
   input  logic [BLK_AW-1:0] blk,
   output logic              forced
);

   logic edge_blk;

   if (BOOT_LAYOUT) begin : g_boot
      assign edge_blk = (blk == '0) || (blk == LAST_BLK);
   end else begin : g_uniform
      assign edge_blk = (blk == LAST_BLK);
   end

   assign forced = vpp_low || (!wp_n && edge_blk);

endmodule

// File: rtl/blk_wprot_ctrl.sv
module blk_wprot_ctrl
   import blk_wprot_pkg::*;
#(
   parameter int NUM_BLOCKS  = 256,
   parameter bit BOOT_LAYOUT = 1'b1,
   localparam int BLK_AW = $clog2(NUM_BLOCKS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic [CMD_W-1:0]  cmd_data,
   input  logic [2:0]        cmd_lines,
   input  logic [BLK_AW-1:0] cmd_blk,
   input  logic              wp_n,
   input  logic              vpp_low,
   input  logic [BLK_AW-1:0] req_blk,
   output logic              req_permit,
   input  logic [BLK_AW-1:0] rd_blk,
   output logic              rd_stored,
   output logic              rd_protected
);

   if (NUM_BLOCKS < 2) begin : g_chk_min
      $error("NUM_BLOCKS must be at least 2");
   end
   if ((1 << BLK_AW) != NUM_BLOCKS) begin : g_chk_pow2
      $error("NUM_BLOCKS must be a power of two");
   end

   logic                  upd_en, upd_val;
   logic [BLK_AW-1:0]     upd_blk;
   logic [NUM_BLOCKS-1:0] prot_vec;
   logic                  forced_req, forced_rd;

   blk_wprot_seq #(.BLK_AW(BLK_AW)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_valid (cmd_valid),
      .cmd_data  (cmd_data),
      .cmd_lines (cmd_lines),
      .cmd_blk   (cmd_blk),
      .upd_en    (upd_en),
      .upd_val   (upd_val),
      .upd_blk   (upd_blk)
   );

   blk_wprot_bits #(.NUM_BLOCKS(NUM_BLOCKS)) u_bits (
      .clk     (clk),
      .rst_n   (rst_n),
      .upd_en  (upd_en),
      .upd_val (upd_val),
      .upd_blk (upd_blk),
      .prot_q  (prot_vec)
   );

   blk_wprot_hwlock #(.NUM_BLOCKS(NUM_BLOCKS), .BOOT_LAYOUT(BOOT_LAYOUT)) u_lock_req (
      .wp_n    (wp_n),
      .vpp_low (vpp_low),
      .blk     (req_blk),
      .forced  (forced_req)
   );

   blk_wprot_hwlock #(.NUM_BLOCKS(NUM_BLOCKS), .BOOT_LAYOUT(BOOT_LAYOUT)) u_lock_rd (
      .wp_n    (wp_n),
      .vpp_low (vpp_low),
      .blk     (rd_blk),
      .forced  (forced_rd)
   );

   assign req_permit   = !prot_vec[req_blk] && !forced_req;
   assign rd_stored    = prot_vec[rd_blk];
   assign rd_protected = prot_vec[rd_blk] || forced_rd;

endmodule

// File: rtl/blk_wprot_chk.sv
module blk_wprot_chk
   import blk_wprot_pkg::*;
#(
   parameter int NUM_BLOCKS = 256,
   localparam int BLK_AW = $clog2(NUM_BLOCKS)
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  cmd_valid,
   input logic [CMD_W-1:0]      cmd_data,
   input logic [2:0]            cmd_lines,
   input logic [BLK_AW-1:0]     cmd_blk,
   input logic                  wp_n,
   input logic                  vpp_low,
   input logic [BLK_AW-1:0]     req_blk,
   input logic                  req_permit,
   input logic [NUM_BLOCKS-1:0] prot_vec
);

   logic seen;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) seen <= 1'b0;
      else        seen <= 1'b1;
   end

   logic wr_lock, wr_exit;
   assign wr_lock = cmd_valid && (cmd_data == OP_LOCK);
   assign wr_exit = cmd_valid && (cmd_data == OP_EXIT);

   p_reset_all_set_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !seen |-> (&prot_vec));

   p_protect_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_lock && cmd_lines == SEL_PROTECT && $past(wr_lock, 1) && $past(wr_lock, 2))
      |=> prot_vec[$past(cmd_blk)]);

   p_unprotect_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_lock && cmd_lines == SEL_UNPROTECT && $past(wr_lock, 1) && $past(wr_lock, 2))
      |=> !prot_vec[$past(cmd_blk)]);

   p_single_change_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(prot_vec ^ $past(prot_vec)) <= 1);

   p_exit_r5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_exit ##1 wr_lock |=> $stable(prot_vec));

   p_bad_sel_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_data == OP_LOCK && cmd_lines != SEL_PROTECT &&
       cmd_lines != SEL_UNPROTECT) |=> $stable(prot_vec));

   p_wp_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!wp_n && req_blk == BLK_AW'(NUM_BLOCKS - 1)) |-> !req_permit);

   p_vpp_r9: assert property (@(posedge clk) disable iff (!rst_n)
      vpp_low |-> !req_permit);

   p_permit_r10: assert property (@(posedge clk) disable iff (!rst_n)
      req_permit |-> !prot_vec[req_blk]);

endmodule

bind blk_wprot_ctrl blk_wprot_chk #(.NUM_BLOCKS(NUM_BLOCKS)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cmd_valid  (cmd_valid),
   .cmd_data   (cmd_data),
   .cmd_lines  (cmd_lines),
   .cmd_blk    (cmd_blk),
   .wp_n       (wp_n),
   .vpp_low    (vpp_low),
   .req_blk    (req_blk),
   .req_permit (req_permit),
   .prot_vec   (prot_vec)
);

// File: tb/blk_wprot_ctrl_tb_top.sv
`timescale 1ns/1ps
module blk_wprot_ctrl_tb_top;

   localparam int N  = 256;
   localparam int AW = 8;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          cmd_valid;
   logic [7:0]    cmd_data;
   logic [2:0]    cmd_lines;
   logic [AW-1:0] cmd_blk;
   logic          wp_n, vpp_low;
   logic [AW-1:0] req_blk, rd_blk;
   logic          permit_b, stored_b, prot_b;
   logic          permit_u, stored_u, prot_u;

   int  n_chk  = 0;
   int  n_fail = 0;
   bit  done   = 1'b0;
   bit  exp_st [N];

   always #2 clk = ~clk;

   blk_wprot_ctrl #(.NUM_BLOCKS(N), .BOOT_LAYOUT(1'b1)) dut_i (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_data(cmd_data),
      .cmd_lines(cmd_lines), .cmd_blk(cmd_blk), .wp_n(wp_n), .vpp_low(vpp_low),
      .req_blk(req_blk), .req_permit(permit_b), .rd_blk(rd_blk),
      .rd_stored(stored_b), .rd_protected(prot_b));

   blk_wprot_ctrl #(.NUM_BLOCKS(N), .BOOT_LAYOUT(1'b0)) dut_u (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_data(cmd_data),
      .cmd_lines(cmd_lines), .cmd_blk(cmd_blk), .wp_n(wp_n), .vpp_low(vpp_low),
      .req_blk(req_blk), .req_permit(permit_u), .rd_blk(rd_blk),
      .rd_stored(stored_u), .rd_protected(prot_u));

   task automatic chk(input int act, input int exp, input string tag);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic issue(input logic [7:0] d, input logic [2:0] l, input int b);
      @(negedge clk);
      cmd_valid = 1'b1; cmd_data = d; cmd_lines = l; cmd_blk = AW'(b);
      @(negedge clk);
      cmd_valid = 1'b0;
   endtask

   // full sweep of both instances against the bench model
   task automatic sweep(input string tag);
      for (int b = 0; b < N; b++) begin
         bit ov_b, ov_u, eff_b, eff_u;
         req_blk = AW'(b); rd_blk = AW'(b);
         #1;
         ov_b  = vpp_low || (!wp_n && (b == 0 || b == N - 1));
         ov_u  = vpp_low || (!wp_n && (b == N - 1));
         eff_b = exp_st[b] || ov_b;
         eff_u = exp_st[b] || ov_u;
         chk(int'(stored_b), int'(exp_st[b]), {tag, " R11 stored boot"});
         chk(int'(stored_u), int'(exp_st[b]), {tag, " R11 stored uniform"});
         chk(int'(prot_b),   int'(eff_b),     {tag, " R11 effective boot"});
         chk(int'(prot_u),   int'(eff_u),     {tag, " R11 effective uniform"});
         chk(int'(permit_b), int'(!eff_b),    {tag, " R10 permit boot"});
         chk(int'(permit_u), int'(!eff_u),    {tag, " R10 permit uniform"});
      end
      @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual running expected finished");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; cmd_valid = 1'b0; cmd_data = '0; cmd_lines = '0; cmd_blk = '0;
      wp_n = 1'b1; vpp_low = 1'b0; req_blk = '0; rd_blk = '0;
      for (int b = 0; b < N; b++) exp_st[b] = 1'b1;
      repeat (3) @(negedge clk);
      sweep("R1 during reset");
      rst_n = 1'b1;
      sweep("R1 after reset");

      // R3 and R4: unlock once, then unprotect every block in turn
      issue(8'h60, 3'b101, 17);
      issue(8'h60, 3'b000, 200);
      for (int b = 0; b < N; b++) begin
         issue(8'h60, 3'b110, b);
         exp_st[b] = 1'b0;
      end
      sweep("R3 R4 bulk unprotect");

      // R8 write-protect pin, both layouts
      wp_n = 1'b0;
      sweep("R8 wp low");
      wp_n = 1'b1;

      // R9 low programming voltage
      vpp_low = 1'b1;
      sweep("R9 vpp low");
      wp_n = 1'b0;
      sweep("R9 vpp and wp low");
      wp_n = 1'b1; vpp_low = 1'b0;

      // R2: protect even blocks while still armed
      for (int b = 0; b < N; b += 2) begin
         issue(8'h60, 3'b010, b);
         exp_st[b] = 1'b1;
      end
      sweep("R2 protect even");

      // R6: every illegal selector on a protected and an unprotected block
      for (int s = 0; s < 8; s++) begin
         if (s != 2 && s != 6) begin
            issue(8'h60, 3'(s), 1);
            issue(8'h60, 3'(s), 2);
         end
      end
      // R4: stray data while armed is ignored and the sequence stays armed
      issue(8'h55, 3'b110, 4);
      issue(8'h00, 3'b010, 5);
      sweep("R6 illegal selectors");
      issue(8'h60, 3'b010, 7);
      exp_st[7] = 1'b1;
      rd_blk = AW'(7); #1;
      chk(int'(stored_b), 1, "R4 still armed after stray data");

      // R5: exit, then a single lock write changes nothing
      issue(8'hF0, 3'b000, 0);
      issue(8'h60, 3'b010, 9);
      rd_blk = AW'(9); #1;
      chk(int'(stored_b), 0, "R5 lone write after exit");
      issue(8'hF0, 3'b000, 0);

      // R7: broken unlock, then two lock writes only re-arm
      issue(8'h60, 3'b000, 0);
      issue(8'h33, 3'b000, 0);
      issue(8'h60, 3'b000, 0);
      issue(8'h60, 3'b010, 11);
      rd_blk = AW'(11); #1;
      chk(int'(stored_b), 0, "R7 broken unlock no update");
      issue(8'h60, 3'b010, 11);
      exp_st[11] = 1'b1;
      rd_blk = AW'(11); #1;
      chk(int'(stored_b), 1, "R7 update after re-arm");
      sweep("R5 R7 final pattern");

      // R1: reset again restores all flags
      @(negedge clk); rst_n = 1'b0;
      for (int b = 0; b < N; b++) exp_st[b] = 1'b1;
      @(negedge clk);
      sweep("R1 second reset");
      rst_n = 1'b1;

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule